// File: doc/BRIEF.md
# Serial Transmitter with Flow Control

This block is the transmit side of a programmable serial port. A processor writes one character at a time into a holding register. The block then moves the character into a shift register and sends it on a single serial line. In asynchronous mode each character goes out as a framed word: a low start bit, then five to eight data bits sent least significant bit first, then an optional parity bit and one or two high stop bits. In synchronous mode only the data bits and the optional parity bit are sent. When nothing is queued, a programmed fill character is sent over and over.

The transmit clock is an input that is slower than the system clock. It is sampled and passed through a synchronizer, and each falling edge is turned into a tick. In asynchronous mode a divisor of 1, 16 or 64 turns these ticks into bit periods. Sending needs both a transmit-enable level and an active-low clear-to-send input. A character accepted while sending was allowed is still sent in full if that permission is withdrawn afterwards. The block gives a ready indication in two forms, an interrupt pin and a status bit, and it gives an empty indication. The mode fields, the fill character and the enable level are static inputs, driven by a command register outside this block.

Top module: `usart_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `txrdy_stat_o` is 1 and `txempty_o` is 1.
- R2: An asynchronous frame is sent in this order: a start bit of 0; then 5 + `word_len_i` data bits (codes 0..3), least significant bit first; then, if `par_en_i` is 1, a parity bit equal to the XOR of the data bits XOR `par_odd_i`; then one stop bit of 1, or two if `stop2_i` is 1.
- R3: In asynchronous mode every bit lasts 1, 16 or 64 periods of `tx_clk_i`, for `baud_sel_i` equal to 0, 1, or 2 and 3 respectively. `txd_o` changes only on a bit boundary, which follows a falling edge of `tx_clk_i`.
- R4: No character starts unless `tx_en_i` is 1 and `cts_n_i` is 0, or unless the character was accepted while both held. A character written while sending is not allowed stays queued, and `txd_o` stays at 1 until sending is allowed again.
- R5: A character accepted while sending is allowed is sent in full, even if `tx_en_i` falls or `cts_n_i` rises afterwards.
- R6: A character waiting in the holding register starts on the bit boundary right after the last stop bit of the current frame, with no idle bit between the two frames.
- R7: `txrdy_stat_o` is 1 exactly when the holding register is empty. It is 0 in the cycle after a write, and it returns to 1 when the shift register takes the character.
- R8: `txrdy_o` is 1 only while `txrdy_stat_o` is 1 and `tx_en_i` is 1.
- R9: `txempty_o` is 0 from the cycle after an accepted write until the frame's last bit has been sent. It stays 1 while a character is queued but sending is not allowed.
- R10: In asynchronous mode `txd_o` is 1 whenever `txempty_o` is 1.
- R11: In synchronous mode (`sync_mode_i` = 1), while sending is allowed and nothing is queued, `sync_char_i` is sent repeatedly in the same word format, with no start or stop bits, and `txempty_o` stays 1. A written character replaces the fill at the next character boundary.
- R12: In synchronous mode, when sending stops being allowed while the fill is being shifted, `txd_o` goes to 1 at once.
- R13: A write in the same cycle in which the shift register takes the previous character keeps the new character. `txrdy_stat_o` stays 0 through that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| wr_en_i | input | 1 | One-cycle strobe that loads a character |
| wr_data_i | input | DW | Character to send |
| tx_en_i | input | 1 | Transmit enable command level |
| cts_n_i | input | 1 | Clear to send, active low |
| sync_mode_i | input | 1 | 1 = synchronous, 0 = asynchronous |
| baud_sel_i | input | 2 | Divisor: 0 = 1, 1 = 16, 2 and 3 = 64 |
| word_len_i | input | WL_W | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| stop2_i | input | 1 | Two stop bits |
| sync_char_i | input | DW | Fill character for synchronous idle |
| tx_clk_i | input | 1 | Transmit clock; bits advance on its falling edge |
| txd_o | output | 1 | Serial data, 1 = mark |
| txrdy_o | output | 1 | Ready pin, gated by enable |
| txrdy_stat_o | output | 1 | Ready status: holding register empty |
| txempty_o | output | 1 | Nothing left to send |

## Verification
The collision that matters is a processor write landing in the same cycle in which the shift register takes the queued character. If it is handled wrongly, the new character is lost or the ready status shows a false empty. The bench provokes the collision by holding the write strobe high for two bit periods. The strobe starts on an idle line with sending allowed, so the first bit boundary pops the register and refills it at the same edge. The result is judged in two ways. The ready status must stay low at every sample of the window. A reference receiver must then decode two identical frames sent back to back.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

   localparam int unsigned MIN_WORD = 5;

   typedef enum logic [1:0] {
      RATE_X1    = 2'd0,
      RATE_X16   = 2'd1,
      RATE_X64   = 2'd2,
      RATE_X64_B = 2'd3
   } rate_e;

endpackage

// File: rtl/utx_tick_gen.sv
module utx_tick_gen
   import usart_tx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_MID     = 16,
   parameter int unsigned DIV_HI      = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_clk_i,
   input  logic       sync_mode_i,
   input  logic [1:0] rate_i,
   output logic       bit_tick_o
);

   localparam int unsigned DCW = $clog2(DIV_HI);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("utx_tick_gen: SYNC_STAGES must be at least 1");
      end
      if (DIV_MID < 2 || DIV_HI <= DIV_MID) begin : g_bad_div
         $error("utx_tick_gen: need 2 <= DIV_MID < DIV_HI");
      end
   endgenerate

   logic          clk_s;
   logic          clk_prev;
   logic          fall;
   logic [DCW-1:0] cnt;
   logic [DCW-1:0] lim;
   rate_e          rate;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic stage;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= 1'b0;
            else        stage <= tx_clk_i;
         end
         assign clk_s = stage;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] stage;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= '0;
            else        stage <= {stage[SYNC_STAGES-2:0], tx_clk_i};
         end
         assign clk_s = stage[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= clk_s;
   end

   assign fall = clk_prev & ~clk_s;
   assign rate = rate_e'(rate_i);

   always_comb begin
      if (sync_mode_i) begin
         lim = '0;
      end else begin
         unique case (rate)
            RATE_X1:  lim = '0;
            RATE_X16: lim = DCW'(DIV_MID - 1);
            default:  lim = DCW'(DIV_HI - 1);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (fall) begin
         if (cnt >= lim) cnt <= '0;
         else            cnt <= cnt + 1'b1;
      end
   end

   assign bit_tick_o = fall & (cnt >= lim);

endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          gate_i,
   input  logic          pop_i,
   output logic [DW-1:0] data_o,
   output logic          full_o,
   output logic          ok_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         full_o <= 1'b0;
         ok_o   <= 1'b0;
      end else if (wr_en_i) begin
         data_o <= wr_data_i;
         full_o <= 1'b1;
         ok_o   <= gate_i;
      end else if (pop_i) begin
         full_o <= 1'b0;
         ok_o   <= 1'b0;
      end else if (gate_i && full_o) begin
         ok_o   <= 1'b1;
      end
   end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import usart_tx_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned WL_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_tick_i,
   input  logic            gate_i,
   input  logic            sync_mode_i,
   input  logic [WL_W-1:0] word_len_i,
   input  logic            par_en_i,
   input  logic            par_odd_i,
   input  logic            stop2_i,
   input  logic [DW-1:0]   sync_char_i,
   input  logic            hold_full_i,
   input  logic            hold_ok_i,
   input  logic [DW-1:0]   hold_data_i,
   output logic            pop_o,
   output logic            txd_o,
   output logic            busy_data_o
);

   localparam int unsigned FW    = DW + 4;
   localparam int unsigned LEN_W = $clog2(FW + 1);

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic [FW-1:0]    bits;
   } frame_t;

   function automatic frame_t frame_of(input logic [DW-1:0] d,
                                       input logic [WL_W-1:0] wl,
                                       input logic sync, input logic pen,
                                       input logic podd, input logic two);
      frame_t        f;
      logic [DW-1:0] mask;
      logic [DW-1:0] dm;
      logic          par;
      int            nb;
      int            off;
      nb = int'(MIN_WORD) + int'(wl);
      if (nb > int'(DW)) nb = int'(DW);
      mask = {DW{1'b1}} >> (int'(DW) - nb);
      dm   = d & mask;
      par  = (^dm) ^ podd;
      off  = sync ? 0 : 1;
      f.bits = '1;
      if (!sync) f.bits[0] = 1'b0;
      f.bits = f.bits & ~(FW'(mask) << off);
      f.bits = f.bits | (FW'(dm) << off);
      off    = off + nb;
      if (pen) begin
         f.bits = f.bits & ~(FW'(1) << off);
         f.bits = f.bits | (FW'(par) << off);
         off    = off + 1;
      end
      if (!sync) off = off + (two ? 2 : 1);
      f.len = LEN_W'(off);
      return f;
   endfunction

   logic          active;
   logic          is_data;
   logic [FW-1:0] sreg;
   logic [LEN_W-1:0] left;
   logic          boundary;
   logic          want;
   frame_t        dframe;
   frame_t        fframe;

   always_comb begin
      boundary = !active || (left == LEN_W'(1));
      want     = hold_full_i && (gate_i || hold_ok_i);
      pop_o    = bit_tick_i && boundary && want;
      dframe   = frame_of(hold_data_i, word_len_i, sync_mode_i, par_en_i,
                          par_odd_i, stop2_i);
      fframe   = frame_of(sync_char_i, word_len_i, sync_mode_i, par_en_i,
                          par_odd_i, stop2_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         is_data <= 1'b0;
         sreg    <= '1;
         left    <= '0;
      end else if (bit_tick_i && boundary) begin
         if (want) begin
            sreg    <= dframe.bits;
            left    <= dframe.len;
            active  <= 1'b1;
            is_data <= 1'b1;
         end else if (sync_mode_i && gate_i) begin
            sreg    <= fframe.bits;
            left    <= fframe.len;
            active  <= 1'b1;
            is_data <= 1'b0;
         end else begin
            sreg    <= '1;
            left    <= '0;
            active  <= 1'b0;
            is_data <= 1'b0;
         end
      end else if (active && !is_data && !gate_i) begin
         active <= 1'b0;
         sreg   <= '1;
      end else if (bit_tick_i) begin
         sreg <= {1'b1, sreg[FW-1:1]};
         left <= left - 1'b1;
      end
   end

   assign txd_o       = (active && (is_data || gate_i)) ? sreg[0] : 1'b1;
   assign busy_data_o = active && is_data;

endmodule

// File: rtl/usart_tx.sv
module usart_tx
   import usart_tx_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned WL_W        = $clog2(DW - MIN_WORD + 1),
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_MID     = 16,
   parameter int unsigned DIV_HI      = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [DW-1:0]   wr_data_i,
   input  logic            tx_en_i,
   input  logic            cts_n_i,
   input  logic            sync_mode_i,
   input  logic [1:0]      baud_sel_i,
   input  logic [WL_W-1:0] word_len_i,
   input  logic            par_en_i,
   input  logic            par_odd_i,
   input  logic            stop2_i,
   input  logic [DW-1:0]   sync_char_i,
   input  logic            tx_clk_i,
   output logic            txd_o,
   output logic            txrdy_o,
   output logic            txrdy_stat_o,
   output logic            txempty_o
);

   generate
      if (DW < MIN_WORD || DW > 16) begin : g_bad_dw
         $error("usart_tx: DW must lie between MIN_WORD and 16");
      end
      if (WL_W < 1) begin : g_bad_wl
         $error("usart_tx: WL_W must be at least 1");
      end
   endgenerate

   logic          gate;
   logic          bit_tick;
   logic          pop;
   logic          hold_full;
   logic          hold_ok;
   logic [DW-1:0] hold_data;
   logic          busy_data;

   assign gate = tx_en_i & ~cts_n_i;

   utx_tick_gen #(
      .SYNC_STAGES (SYNC_STAGES),
      .DIV_MID     (DIV_MID),
      .DIV_HI      (DIV_HI)
   ) i_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_clk_i    (tx_clk_i),
      .sync_mode_i (sync_mode_i),
      .rate_i      (baud_sel_i),
      .bit_tick_o  (bit_tick)
   );

   utx_hold #(
      .DW        (DW)
   ) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .gate_i    (gate),
      .pop_i     (pop),
      .data_o    (hold_data),
      .full_o    (hold_full),
      .ok_o      (hold_ok)
   );

   utx_shifter #(
      .DW          (DW),
      .WL_W        (WL_W)
   ) i_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick_i  (bit_tick),
      .gate_i      (gate),
      .sync_mode_i (sync_mode_i),
      .word_len_i  (word_len_i),
      .par_en_i    (par_en_i),
      .par_odd_i   (par_odd_i),
      .stop2_i     (stop2_i),
      .sync_char_i (sync_char_i),
      .hold_full_i (hold_full),
      .hold_ok_i   (hold_ok),
      .hold_data_i (hold_data),
      .pop_o       (pop),
      .txd_o       (txd_o),
      .busy_data_o (busy_data)
   );

   assign txrdy_stat_o = ~hold_full;
   assign txrdy_o      = ~hold_full & tx_en_i;
   assign txempty_o    = ~busy_data & ~(hold_full & (gate | hold_ok));

endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en_i,
   input logic tx_en_i,
   input logic cts_n_i,
   input logic sync_mode_i,
   input logic txd_o,
   input logic txrdy_o,
   input logic txrdy_stat_o,
   input logic txempty_o,
   input logic bit_tick,
   input logic pop,
   input logic hold_ok,
   input logic busy_data
);

   // R3
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode_i && !$past(bit_tick)) |-> $stable(txd_o));

   // R7 R13
   load_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> !txrdy_stat_o);

   // R7
   rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txrdy_stat_o) |-> $past(pop));

   // R4
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_data) |-> ($past(tx_en_i && !cts_n_i) || $past(hold_ok)));

   // R9
   empty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_data |-> !txempty_o);

   // R10
   async_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode_i && txempty_o) |-> txd_o);

   // R8
   rdy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txrdy_o |-> (tx_en_i && txrdy_stat_o));

   // R12
   sync_gate_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode_i && !busy_data && !(tx_en_i && !cts_n_i)) |-> txd_o);

endmodule

bind usart_tx usart_tx_chk i_usart_tx_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en_i      (wr_en_i),
   .tx_en_i      (tx_en_i),
   .cts_n_i      (cts_n_i),
   .sync_mode_i  (sync_mode_i),
   .txd_o        (txd_o),
   .txrdy_o      (txrdy_o),
   .txrdy_stat_o (txrdy_stat_o),
   .txempty_o    (txempty_o),
   .bit_tick     (bit_tick),
   .pop          (pop),
   .hold_ok      (hold_ok),
   .busy_data    (busy_data)
);

// File: tb/test_usart_tx.sv
`timescale 1ns/1ps
module test_usart_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tx_en = 1'b0;
   logic       cts_n = 1'b1;
   logic       sync_mode = 1'b0;
   logic [1:0] baud_sel = 2'd0;
   logic [1:0] word_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       stop2 = 1'b0;
   logic [7:0] sync_char = 8'h16;
   logic       txc = 1'b0;
   logic       txd;
   logic       txrdy;
   logic       txrdy_stat;
   logic       txempty;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;
   bit log_on = 0;
   int lidx = 0;
   logic lbits [256];

   always #2.5 clk = ~clk;

   usart_tx i_usart_tx (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .tx_en_i(tx_en), .cts_n_i(cts_n), .sync_mode_i(sync_mode),
      .baud_sel_i(baud_sel), .word_len_i(word_len), .par_en_i(par_en),
      .par_odd_i(par_odd), .stop2_i(stop2), .sync_char_i(sync_char),
      .tx_clk_i(txc), .txd_o(txd), .txrdy_o(txrdy),
      .txrdy_stat_o(txrdy_stat), .txempty_o(txempty)
   );

   // transmit clock: 8 system clocks per period; serial log taken just before each fall
   initial begin
      forever begin
         repeat (4) @(negedge clk);
         txc = 1'b1;
         repeat (4) @(negedge clk);
         if (log_on && lidx < 256) begin
            lbits[lidx] = txd;
            lidx++;
         end
         txc = 1'b0;
      end
   end

   // baud_sel[14:13] word_len[12:11] par_en[10] par_odd[9] stop2[8] data[7:0]
   localparam logic [14:0] VEC [8] = '{
      {2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 8'hA5},
      {2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h13},
      {2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 8'h3C},
      {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 8'hFF},
      {2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 8'h2A},
      {2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 8'h81},
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00},
      {2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 8'h15}
   };

   task automatic check(input bit c, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!c) begin
         nfail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", 195000, 0);
      finish_run();
   end

   function automatic int bitp_of(input logic [1:0] sel);
      return 8 * ((sel == 2'd0) ? 1 : (sel == 2'd1) ? 16 : 64);
   endfunction

   task automatic write_char(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // reference receiver: waits for a start edge, samples each bit at its centre
   task automatic rx_frame(input int bitp, input int nb, input bit pen, input bit s2,
                           output logic [7:0] d, output logic p, output bit start_ok,
                           output bit stop_ok, output bit got, output int waited);
      int t = 0;
      d = '0; p = 1'b0; start_ok = 0; stop_ok = 1; got = 0;
      while (txd !== 1'b0 && t < 40 * bitp) begin
         @(negedge clk);
         t++;
      end
      waited = t;
      if (txd !== 1'b0) return;
      got = 1;
      repeat (bitp / 2) @(negedge clk);
      start_ok = (txd == 1'b0);
      for (int i = 0; i < nb; i++) begin
         repeat (bitp) @(negedge clk);
         d[i] = txd;
      end
      if (pen) begin
         repeat (bitp) @(negedge clk);
         p = txd;
      end
      for (int s = 0; s < (s2 ? 2 : 1); s++) begin
         repeat (bitp) @(negedge clk);
         if (txd !== 1'b1) stop_ok = 0;
      end
   endtask

   function automatic logic [7:0] window(input int idx);
      logic [7:0] w;
      for (int i = 0; i < 8; i++) w[i] = lbits[idx + i];
      return w;
   endfunction

   initial begin
      logic [7:0] d;
      logic       p;
      bit         st, sp, got;
      int         waited;
      int         bitp;
      int         prevp;
      int         bad;
      int         k;
      bit         hit;
      logic [7:0] expd;
      int         nb;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R8 pin masked while disabled
      check(txd == 1'b1, "R1", "txd after reset", txd, 1);
      check(txrdy_stat == 1'b1, "R1", "ready status after reset", txrdy_stat, 1);
      check(txempty == 1'b1, "R1", "empty after reset", txempty, 1);
      check(txrdy == 1'b0, "R8", "ready pin with enable off", txrdy, 0);

      // table-driven frames
      prevp = 8;
      tx_en = 1'b1;
      cts_n = 1'b0;
      for (int v = 0; v < 8; v++) begin
         repeat (2 * prevp) @(negedge clk);
         baud_sel = VEC[v][14:13];
         word_len = VEC[v][12:11];
         par_en   = VEC[v][10];
         par_odd  = VEC[v][9];
         stop2    = VEC[v][8];
         bitp     = bitp_of(baud_sel);
         prevp    = bitp;
         nb       = 5 + int'(word_len);
         expd     = VEC[v][7:0] & ((8'd1 << nb) - 8'd1);
         @(negedge clk);
         check(txrdy == 1'b1, "R8", "ready pin with enable on", txrdy, 1);
         write_char(VEC[v][7:0]);
         check(txrdy_stat == 1'b0, "R7", "status after write", txrdy_stat, 0);
         check(txempty == 1'b0, "R9", "empty after write", txempty, 0);
         rx_frame(bitp, nb, par_en, stop2, d, p, st, sp, got, waited);
         check(got, "R4", "frame started", got, 1);
         check(st, "R2", "start bit", st, 1);
         check(d == expd, "R2 R3", "data bits", d, expd);
         if (par_en) check(p == ((^expd) ^ par_odd), "R2", "parity bit", p, (^expd) ^ par_odd);
         check(sp, "R2", "stop bits", sp, 1);
         check(txrdy_stat == 1'b1, "R7", "status after frame taken", txrdy_stat, 1);
         repeat (bitp) @(negedge clk);
         check(txempty == 1'b1, "R9", "empty after frame", txempty, 1);
         check(txd == 1'b1, "R10", "mark when empty", txd, 1);
      end

      // R6 back-to-back frames, 1x 8N1
      repeat (2 * prevp) @(negedge clk);
      baud_sel = 2'd0; word_len = 2'd3; par_en = 0; stop2 = 0; bitp = 8; prevp = 8;
      write_char(8'h11);
      k = 0;
      while (txrdy_stat !== 1'b1 && k < 200) begin @(negedge clk); k++; end
      write_char(8'h22);
      rx_frame(bitp, 8, 0, 0, d, p, st, sp, got, waited);
      check(d == 8'h11 && sp, "R6", "first of pair", d, 8'h11);
      rx_frame(bitp, 8, 0, 0, d, p, st, sp, got, waited);
      check(d == 8'h22 && got, "R6", "second of pair", d, 8'h22);
      check(waited <= bitp / 2 + 2, "R6", "gap before second start", waited, bitp / 2);

      // R13 write colliding with shift-register load
      repeat (4 * bitp) @(negedge clk);
      bad = 0;
      fork
         rx_frame(bitp, 8, 0, 0, d, p, st, sp, got, waited);
         begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = 8'h5A;
            for (int c = 0; c < 2 * bitp; c++) begin
               @(negedge clk);
               if (txrdy_stat !== 1'b0) bad++;
            end
            wr_en = 1'b0;
         end
      join
      check(bad == 0, "R13", "status during collision window", bad, 0);
      check(d == 8'h5A && got, "R13", "first frame of collision", d, 8'h5A);
      rx_frame(bitp, 8, 0, 0, d, p, st, sp, got, waited);
      check(d == 8'h5A && got, "R13", "kept character sent", d, 8'h5A);

      // R4 clear-to-send inactive blocks a new frame
      repeat (4 * bitp) @(negedge clk);
      cts_n = 1'b1;
      write_char(8'h33);
      bad = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (txd !== 1'b1) bad++;
      end
      check(bad == 0, "R4", "mark while cts inactive", bad, 0);
      check(txrdy_stat == 1'b0, "R7", "queued status", txrdy_stat, 0);
      check(txempty == 1'b1, "R9", "empty while gated", txempty, 1);
      cts_n = 1'b0;
      rx_frame(bitp, 8, 0, 0, d, p, st, sp, got, waited);
      check(d == 8'h33 && got, "R4", "sent after cts", d, 8'h33);

      // R5 drain after enable removed, 16x
      repeat (4 * bitp) @(negedge clk);
      baud_sel = 2'd1; bitp = 128;
      write_char(8'h6C);
      tx_en = 1'b0;
      rx_frame(bitp, 8, 0, 0, d, p, st, sp, got, waited);
      check(d == 8'h6C && got && sp, "R5", "drained character", d, 8'h6C);
      bad = 0;
      for (int c = 0; c < 4 * bitp; c++) begin
         @(negedge clk);
         if (txd !== 1'b1) bad++;
      end
      check(bad == 0, "R4", "mark after drain while disabled", bad, 0);

      // R11 synchronous fill and data replacement
      sync_mode = 1'b1; baud_sel = 2'd0; sync_char = 8'h16;
      lidx = 0;
      log_on = 1;
      tx_en = 1'b1;
      bad = 0;
      for (int c = 0; c < 48 * 8; c++) begin
         @(negedge clk);
         if (txempty !== 1'b1) bad++;
      end
      check(bad == 0, "R11", "empty during fill", bad, 0);
      write_char(8'hC3);
      repeat (40 * 8) @(negedge clk);
      log_on = 0;
      k = -1;
      for (int a = 0; a < 8; a++) begin
         if (k < 0 && window(8 + a) == 8'h16 && window(16 + a) == 8'h16 &&
             window(24 + a) == 8'h16) k = a;
      end
      check(k >= 0, "R11", "fill character found", k, 0);
      hit = 0;
      if (k >= 0) begin
         for (int m = 8 + k; m + 7 < lidx; m += 8) begin
            if (window(m) == 8'hC3) hit = 1;
         end
      end
      check(hit, "R11", "data replaced fill", hit, 1);

      // R12 fill stops at once when gate closes
      @(negedge clk);
      tx_en = 1'b0;
      bad = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (txd !== 1'b1) bad++;
      end
      check(bad == 0, "R12", "mark after gate closes in fill", bad, 0);

      finish_run();
   end

endmodule